// File: doc/BRIEF.md
# Multi-Mode Register File

A 64-entry storage block whose words are 20 bits wide: a 16-bit data value with 4 control bits beside it. A two-bit configuration input selects how the one array is used. As a dual-ported RAM, writes and reads each carry their own address. As a FIFO, both addresses are ignored: entries leave in the order they arrived, and empty, full and error flags report the queue state. In sort mode, writes go to any chosen address, and reads walk the array in rising address order from an internal pointer. A restart input sends that pointer back to entry 0.

A write request and a read request can each be accepted in every cycle. Every accepted read returns its word two cycles after the request, and `rd_valid` marks that word for one cycle. A read the block refuses, such as a FIFO read while the queue is empty, produces no `rd_valid` pulse. A typical use is a small reorder buffer: results are written to slots by index in sort mode and then streamed out in order.

Top module: `modal_regfile`

## Requirements
- R1: In RAM mode, a word written to an address is returned, all 20 bits unchanged, by a later read of that address. The read and write addresses are independent.
- R2: A read accepted with its request presented in cycle c drives `rd_valid` high and `rd_data` with the word in cycle c+2. `rd_valid` is high for one cycle per accepted read and low otherwise. Reads may be accepted in back-to-back cycles.
- R3: In RAM mode, a read and a write to the same address in the same cycle return the data stored before that write.
- R4: `cfg_mode` encoding: 0 selects RAM, 1 selects FIFO, 2 selects sort, and 3 behaves exactly as RAM.
- R5: In FIFO mode, reads return words in the order they were written, and `wr_addr` and `rd_addr` are ignored.
- R6: `fifo_empty` is high when 0 words are queued. `fifo_full` is high when 64 words are queued. The two are never high together.
- R7: In FIFO mode, a write while full and a read while empty are ignored: nothing is stored and no `rd_valid` pulse occurs. Either one sets `fifo_err` on the next edge, and `fifo_err` stays high until reset.
- R8: In FIFO mode, a read and a write in the same cycle, with the queue neither empty nor full, are both accepted and leave the queued count unchanged.
- R9: In sort mode, writes store at `wr_addr`. Reads ignore `rd_addr` and return entries in rising address order, starting from entry 0 after reset.
- R10: The sort read pointer wraps from entry 63 back to entry 0.
- R11: `sort_restart` sets the sort pointer to entry 0. A read in the same cycle returns entry 0, and the next read returns entry 1.
- R12: After reset, `rd_valid`, `fifo_full` and `fifo_err` are low and `fifo_empty` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_mode | input | 2 | Mode: 0 RAM, 1 FIFO, 2 sort, 3 RAM |
| wr_req | input | 1 | Write request |
| wr_addr | input | 6 | Write address (RAM and sort modes) |
| wr_data | input | 20 | Write word: data in bits 15:0, control in bits 19:16 |
| rd_req | input | 1 | Read request |
| rd_addr | input | 6 | Read address (RAM mode only) |
| sort_restart | input | 1 | Return the sort read pointer to entry 0 |
| rd_data | output | 20 | Read word, two cycles after the request |
| rd_valid | output | 1 | `rd_data` holds the word of an accepted read |
| fifo_empty | output | 1 | No words queued |
| fifo_full | output | 1 | 64 words queued |
| fifo_err | output | 1 | Sticky: a FIFO access was refused |

## Verification
The properties assume that `cfg_mode`, `wr_req` and `rd_req` are defined in every cycle after reset, and that reset is held across at least one rising edge. They also assume that any X on the addresses or write data can reach only the stored words, never the flags or `rd_valid`. The bench drives every input from time zero. It changes the mode only after the read pipeline has drained, so no request is pending across a mode switch. It deliberately sends refused FIFO accesses to exercise the sticky error path.

// File: rtl/modal_regfile_pkg.sv
// Package: shared sizes and the mode encoding of the multi-mode register file.
// Assumes: DEPTH is a power of two so that pointers wrap naturally.
package modal_regfile_pkg;
    localparam int DATA_W  = 16;
    localparam int CTRL_W  = 4;
    localparam int WORD_W  = DATA_W + CTRL_W;
    localparam int DEPTH   = 64;

    typedef enum logic [1:0] {
        MODE_RAM  = 2'd0,
        MODE_FIFO = 2'd1,
        MODE_SORT = 2'd2
    } mode_t;
endpackage

// File: rtl/regfile_mem.sv
// Module: storage array plus a two-stage read pipeline.
// Does: one write and one read per cycle; read data and its valid flag leave
//       two register stages after the read is accepted.
// Assumes: the caller has already resolved addresses and accept decisions.
module regfile_mem #(
    parameter int W     = 20,
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [W-1:0]  wr_data,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    output logic [W-1:0]  rd_data,
    output logic          rd_valid
);
    logic [W-1:0] mem [DEPTH];
    logic [W-1:0] s1_data;
    logic         s1_valid;

    // Store the accepted write word.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    // Stage 1 data: sample the array before any same-edge write lands.
    always_ff @(posedge clk) begin
        if (rd_en) s1_data <= mem[rd_addr];
    end

    // Stage 1 valid: remember whether a read was accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) s1_valid <= 1'b0;
        else        s1_valid <= rd_en;
    end

    // Stage 2: present the word and its valid flag at the outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= s1_valid;
            if (s1_valid) rd_data <= s1_data;
        end
    end
endmodule

// File: rtl/fifo_ctrl.sv
// Module: queue bookkeeping for FIFO mode.
// Does: keeps write/read pointers and the occupancy count, decides which
//       requests are accepted, and raises a sticky error on refused ones.
// Assumes: requests count only while en is high; DEPTH is a power of two.
module fifo_ctrl #(
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          wr_req,
    input  logic          rd_req,
    output logic          wr_ok,
    output logic          rd_ok,
    output logic [AW-1:0] wr_ptr,
    output logic [AW-1:0] rd_ptr,
    output logic          empty,
    output logic          full,
    output logic          err
);
    logic [CW-1:0] count;

    assign empty = (count == '0);
    assign full  = (count == CW'(DEPTH));
    assign wr_ok = en && wr_req && !full;
    assign rd_ok = en && rd_req && !empty;

    // Advance pointers and occupancy for accepted accesses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (wr_ok) wr_ptr <= wr_ptr + 1'b1;
            if (rd_ok) rd_ptr <= rd_ptr + 1'b1;
            case ({wr_ok, rd_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // Latch any refused access until reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            err <= 1'b0;
        else if (en && ((wr_req && full) || (rd_req && empty)))
            err <= 1'b1;
    end
endmodule

// File: rtl/seq_ptr.sv
// Module: sequential read pointer for sort mode.
// Does: gives the current read address; restart forces entry 0 for this
//       cycle and the pointer steps past each read, wrapping at the end.
// Assumes: DEPTH is a power of two.
module seq_ptr #(
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv,
    input  logic          restart,
    output logic [AW-1:0] addr
);
    logic [AW-1:0] ptr;

    assign addr = restart ? '0 : ptr;

    // Move to the entry after the one just read, or hold.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr <= '0;
        else if (restart || adv)
            ptr <= addr + {{(AW-1){1'b0}}, adv};
    end
endmodule

// File: rtl/modal_regfile.sv
// Module: top of the multi-mode register file.
// Does: routes requests and addresses to one array according to cfg_mode
//       (RAM, FIFO or sort; code 3 behaves as RAM).
// Assumes: cfg_mode changes only when no request is pending.
module modal_regfile
    import modal_regfile_pkg::*;
#(
    parameter int WIDTH = WORD_W,
    parameter int ENTRIES = DEPTH,
    localparam int AW = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       cfg_mode,
    input  logic             wr_req,
    input  logic [AW-1:0]    wr_addr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_req,
    input  logic [AW-1:0]    rd_addr,
    input  logic             sort_restart,
    output logic [WIDTH-1:0] rd_data,
    output logic             rd_valid,
    output logic             fifo_empty,
    output logic             fifo_full,
    output logic             fifo_err
);
    logic          is_fifo, is_sort;
    logic          q_wr_ok, q_rd_ok;
    logic [AW-1:0] q_wr_ptr, q_rd_ptr, s_addr;
    logic          mem_wr_en, mem_rd_en;
    logic [AW-1:0] mem_wa, mem_ra;

    assign is_fifo = (cfg_mode == MODE_FIFO);
    assign is_sort = (cfg_mode == MODE_SORT);

    fifo_ctrl #(.DEPTH(ENTRIES)) u_fifo (
        .clk(clk), .rst_n(rst_n), .en(is_fifo),
        .wr_req(wr_req), .rd_req(rd_req),
        .wr_ok(q_wr_ok), .rd_ok(q_rd_ok),
        .wr_ptr(q_wr_ptr), .rd_ptr(q_rd_ptr),
        .empty(fifo_empty), .full(fifo_full), .err(fifo_err)
    );

    seq_ptr #(.DEPTH(ENTRIES)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .adv(is_sort && rd_req), .restart(sort_restart),
        .addr(s_addr)
    );

    // Select accept decisions and addresses for the active mode.
    always_comb begin
        mem_wr_en = is_fifo ? q_wr_ok  : wr_req;
        mem_wa    = is_fifo ? q_wr_ptr : wr_addr;
        mem_rd_en = is_fifo ? q_rd_ok  : rd_req;
        if (is_fifo)      mem_ra = q_rd_ptr;
        else if (is_sort) mem_ra = s_addr;
        else              mem_ra = rd_addr;
    end

    regfile_mem #(.W(WIDTH), .DEPTH(ENTRIES)) u_mem (
        .clk(clk), .rst_n(rst_n),
        .wr_en(mem_wr_en), .wr_addr(mem_wa), .wr_data(wr_data),
        .rd_en(mem_rd_en), .rd_addr(mem_ra),
        .rd_data(rd_data), .rd_valid(rd_valid)
    );
endmodule

// File: rtl/modal_regfile_chk.sv
// Module: property checker for modal_regfile, attached by bind.
// Assumes: mode and request inputs are known in every cycle after reset.
module modal_regfile_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] cfg_mode,
    input logic       wr_req,
    input logic       rd_req,
    input logic       rd_valid,
    input logic       fifo_empty,
    input logic       fifo_full,
    input logic       fifo_err
);
    // R12
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (!rd_valid && fifo_empty && !fifo_full && !fifo_err));

    // R6
    flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(fifo_empty && fifo_full));

    // R6
    leave_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode == 2'd1 && wr_req && !rd_req && fifo_empty) |=> !fifo_empty);

    // R7
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_err |=> fifo_err);

    // R7
    full_write_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode == 2'd1 && wr_req && fifo_full) |=> fifo_err);

    // R7
    empty_read_novalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode == 2'd1 && rd_req && fifo_empty) |-> ##2 !rd_valid);

    // R2
    read_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode != 2'd1 && rd_req) |-> ##2 rd_valid);

    // R2
    valid_has_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(rd_req, 2));
endmodule

bind modal_regfile modal_regfile_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode),
    .wr_req(wr_req), .rd_req(rd_req), .rd_valid(rd_valid),
    .fifo_empty(fifo_empty), .fifo_full(fifo_full), .fifo_err(fifo_err)
);

// File: tb/modal_regfile_tb.sv
// Bench: sweeps every entry in each mode and compares against values
// computed from the requirements.
module modal_regfile_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_mode = 2'd0;
    logic        wr_req = 1'b0;
    logic [5:0]  wr_addr = '0;
    logic [19:0] wr_data = '0;
    logic        rd_req = 1'b0;
    logic [5:0]  rd_addr = '0;
    logic        sort_restart = 1'b0;
    logic [19:0] rd_data;
    logic        rd_valid, fifo_empty, fifo_full, fifo_err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // expected results of the two requests still in flight
    logic        p0_v = 1'b0, p1_v = 1'b0;
    logic [19:0] p0_d = '0,   p1_d = '0;
    string       p0_t = "R2", p1_t = "R2";

    always #2.5 clk = ~clk;

    modal_regfile u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode),
        .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_req(rd_req), .rd_addr(rd_addr), .sort_restart(sort_restart),
        .rd_data(rd_data), .rd_valid(rd_valid),
        .fifo_empty(fifo_empty), .fifo_full(fifo_full), .fifo_err(fifo_err)
    );

    function automatic logic [19:0] ram_val(input int a);
        return 20'((a * 2731 + 517) ^ (a << 13));
    endfunction
    function automatic logic [19:0] fifo_val(input int k);
        return 20'(k * 40503 + 11);
    endfunction
    function automatic logic [19:0] sort_val(input int a);
        return 20'((a * 977) ^ 'hA5A5A);
    endfunction

    // One cycle: check the output owed by the request of two cycles ago,
    // then drive this cycle's inputs and record what they must produce.
    task automatic step(input logic wr, input int wa, input logic [19:0] wd,
                        input logic rd, input int ra, input logic rs,
                        input logic ev, input logic [19:0] ed, input string tag);
        @(negedge clk);
        checks++;
        if (rd_valid !== p1_v) begin
            errors++;
            $display("FAIL %s rd_valid actual %b expected %b", p1_t, rd_valid, p1_v);
        end else if (p1_v && rd_data !== p1_d) begin
            errors++;
            $display("FAIL %s rd_data actual %h expected %h", p1_t, rd_data, p1_d);
        end
        p1_v = p0_v; p1_d = p0_d; p1_t = p0_t;
        p0_v = ev;   p0_d = ed;   p0_t = tag;
        wr_req = wr; wr_addr = 6'(wa); wr_data = wd;
        rd_req = rd; rd_addr = 6'(ra); sort_restart = rs;
    endtask

    task automatic idle(input string tag);
        step(1'b0, 0, '0, 1'b0, 0, 1'b0, 1'b0, '0, tag);
    endtask

    task automatic drain(input string tag);
        idle(tag); idle(tag);
    endtask

    task automatic check_flags(input logic e, input logic f, input logic er,
                               input string tag);
        checks++;
        if (fifo_empty !== e || fifo_full !== f || fifo_err !== er) begin
            errors++;
            $display("FAIL %s flags empty/full/err actual %b%b%b expected %b%b%b",
                     tag, fifo_empty, fifo_full, fifo_err, e, f, er);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        wr_req = 1'b0; rd_req = 1'b0; sort_restart = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        p0_v = 1'b0; p1_v = 1'b0;
    endtask

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R12: reset state
        checks++;
        if (rd_valid !== 1'b0) begin
            errors++;
            $display("FAIL R12 rd_valid actual %b expected 0", rd_valid);
        end
        check_flags(1'b1, 1'b0, 1'b0, "R12");

        // R1, R2: RAM mode, fill then read back-to-back in permuted order
        cfg_mode = 2'd0;
        for (int a = 0; a < 64; a++)
            step(1'b1, a, ram_val(a), 1'b0, 0, 1'b0, 1'b0, '0, "R1");
        for (int a = 0; a < 64; a++) begin
            int ra = (a * 37) % 64;
            step(1'b0, 0, '0, 1'b1, ra, 1'b0, 1'b1, ram_val(ra), "R1");
        end
        drain("R2");
        // R2: isolated reads with gaps give single valid pulses
        step(1'b0, 0, '0, 1'b1, 7, 1'b0, 1'b1, ram_val(7), "R2");
        idle("R2");
        step(1'b0, 0, '0, 1'b1, 9, 1'b0, 1'b1, ram_val(9), "R2");
        drain("R2");

        // R3: same-address read and write return old data
        step(1'b1, 10, 20'hBEEF1, 1'b1, 10, 1'b0, 1'b1, ram_val(10), "R3");
        step(1'b0, 0, '0, 1'b1, 10, 1'b0, 1'b1, 20'hBEEF1, "R3");
        drain("R3");

        // R4: code 3 behaves as RAM
        cfg_mode = 2'd3;
        step(1'b1, 20, 20'h3C0DE, 1'b0, 0, 1'b0, 1'b0, '0, "R4");
        step(1'b0, 0, '0, 1'b1, 20, 1'b0, 1'b1, 20'h3C0DE, "R4");
        step(1'b0, 0, '0, 1'b1, 21, 1'b0, 1'b1, ram_val(21), "R4");
        drain("R4");

        // R7: FIFO read while empty
        cfg_mode = 2'd1;
        do_reset();
        step(1'b0, 0, '0, 1'b1, 5, 1'b0, 1'b0, '0, "R7");
        drain("R7");
        check_flags(1'b1, 1'b0, 1'b1, "R7");
        idle("R7");
        check_flags(1'b1, 1'b0, 1'b1, "R7");

        // R5, R6, R7: fill, overfill, then drain in order
        do_reset();
        check_flags(1'b1, 1'b0, 1'b0, "R12");
        for (int k = 0; k < 64; k++)
            step(1'b1, 63 - k, fifo_val(k), 1'b0, 0, 1'b0, 1'b0, '0, "R5");
        idle("R6");
        check_flags(1'b0, 1'b1, 1'b0, "R6");
        step(1'b1, 0, fifo_val(99), 1'b0, 0, 1'b0, 1'b0, '0, "R7");
        idle("R7");
        check_flags(1'b0, 1'b1, 1'b1, "R7");
        for (int k = 0; k < 64; k++)
            step(1'b0, 0, '0, 1'b1, k ^ 21, 1'b0, 1'b1, fifo_val(k), "R5");
        drain("R7");
        check_flags(1'b1, 1'b0, 1'b1, "R6");

        // R8: simultaneous push and pop keep the count
        do_reset();
        for (int k = 0; k < 3; k++)
            step(1'b1, 0, fifo_val(k), 1'b0, 0, 1'b0, 1'b0, '0, "R8");
        for (int k = 3; k < 8; k++)
            step(1'b1, 0, fifo_val(k), 1'b1, 0, 1'b0, 1'b1, fifo_val(k - 3), "R8");
        idle("R8");
        check_flags(1'b0, 1'b0, 1'b0, "R8");
        for (int k = 5; k < 8; k++)
            step(1'b0, 0, '0, 1'b1, 0, 1'b0, 1'b1, fifo_val(k), "R8");
        drain("R8");
        check_flags(1'b1, 1'b0, 1'b0, "R8");

        // R9: sort mode, scattered writes, sequential reads
        cfg_mode = 2'd2;
        do_reset();
        for (int a = 63; a >= 0; a--)
            step(1'b1, a, sort_val(a), 1'b0, 0, 1'b0, 1'b0, '0, "R9");
        for (int i = 0; i < 64; i++)
            step(1'b0, 0, '0, 1'b1, 63 - i, 1'b0, 1'b1, sort_val(i), "R9");
        // R10: wrap to entry 0
        step(1'b0, 0, '0, 1'b1, 40, 1'b0, 1'b1, sort_val(0), "R10");
        step(1'b0, 0, '0, 1'b1, 40, 1'b0, 1'b1, sort_val(1), "R10");
        step(1'b0, 0, '0, 1'b1, 40, 1'b0, 1'b1, sort_val(2), "R10");
        // R11: restart with a read, then restart alone
        step(1'b0, 0, '0, 1'b1, 33, 1'b1, 1'b1, sort_val(0), "R11");
        step(1'b0, 0, '0, 1'b1, 33, 1'b0, 1'b1, sort_val(1), "R11");
        step(1'b0, 0, '0, 1'b1, 33, 1'b0, 1'b1, sort_val(2), "R11");
        step(1'b0, 0, '0, 1'b0, 0, 1'b1, 1'b0, '0, "R11");
        step(1'b0, 0, '0, 1'b1, 12, 1'b0, 1'b1, sort_val(0), "R11");
        drain("R11");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule